// File: doc/BRIEF.md
# I2C Role and Direction Tracker

This block is the control core of a two-wire serial bus controller. It holds two flags. One says whether the device is the bus master or a slave. The other says whether it transmits or receives. It also holds a programmable 7-bit own address and a format selector. It does not shift bits or generate bus timing. Instead, it takes decoded bus events as inputs: start (including repeated start), stop, arbitration loss, "first byte complete" and "acknowledge sampled". From these it keeps the flags in step with the transfer, with no software involvement.

In slave mode, the first byte after a start is compared against the own address. On a match, the address-hit output goes high and the transmit flag follows the received direction bit. In master mode, the first byte is the address the device sent. Once the slave acknowledges it, the transmit flag takes the inverse of the direction bit that was sent. In free data format, no byte is treated as an address and the hardware never touches the transmit flag. Software writes the role and direction flags through a control strobe. Any hardware update in the same cycle overrides that write.

Top module: `i2crd_tracker`

## Requirements
- R1: After reset, is_master, is_xmit and addr_hit are 0, the own address is 0 and the addressing format is selected.
- R2: A cfg_we pulse loads cfg_wdata: bits 7..1 become the own address and bit 0 selects the format (0 = addressing, 1 = free data). The new value applies from the next cycle.
- R3: A ctrl_we pulse loads is_master from ctrl_master and is_xmit from ctrl_xmit on the next cycle.
- R4: bus_stop or bus_arb_lost clears is_master, is_xmit and addr_hit on the next cycle. This clear overrides a ctrl_we write in the same cycle.
- R5: As a slave in addressing format, a first byte whose bits 7..1 equal the own address sets addr_hit on the next cycle and loads is_xmit from bit 0 of that byte.
- R6: As a slave in addressing format, a first byte that does not match leaves both flags unchanged and addr_hit low. Later bytes are ignored until the next bus_start.
- R7: As a master in addressing format, the first byte is never compared and never sets addr_hit. An ack_valid with ack_ok=1 that follows it sets is_xmit to the inverse of bit 0 of that byte on the next cycle.
- R8: As a master, an ack_valid with ack_ok=0 after the first byte leaves is_xmit unchanged.
- R9: In free data format, the first byte is not compared, addr_hit stays low and the hardware never changes is_xmit.
- R10: addr_hit stays high through later bytes and falls on the cycle after a bus_start or a stop or arbitration loss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Load own address and format selector |
| cfg_wdata | input | 8 | Bits 7..1 own address, bit 0 format (1 = free data) |
| ctrl_we | input | 1 | Software write of the role and direction flags |
| ctrl_master | input | 1 | Role value to write (1 = master) |
| ctrl_xmit | input | 1 | Direction value to write (1 = transmitter) |
| bus_start | input | 1 | Start or repeated start seen on the bus |
| bus_stop | input | 1 | Stop seen on the bus |
| bus_arb_lost | input | 1 | Arbitration lost |
| byte_valid | input | 1 | A byte has completed (eighth bit shifted) |
| byte_data | input | 8 | Completed byte, bit 0 is the direction bit of an address |
| ack_valid | input | 1 | Acknowledge bit sampled |
| ack_ok | input | 1 | 1 when the sampled bit was an acknowledge |
| is_master | output | 1 | Role flag |
| is_xmit | output | 1 | Direction flag |
| addr_hit | output | 1 | Own address recognised in the current transfer |

## Verification
The bound checker watches several rules on every cycle. A stop or arbitration loss always clears all three outputs. A restart always drops the hit. A NACK, or operation in free data format, never moves the direction flag. The hit can only rise after a byte received as slave. A software write of the role always lands unless a clear overrides it. Other behaviour needs a whole bus sequence and is shown only by the bench's scenarios. This covers the direction rules for master and slave, ignoring bytes after an address miss, persistence of the hit across data bytes, and the effect of reset on the stored own address.

// File: rtl/i2crd_pkg.sv
package i2crd_pkg;

   // Position in the current transfer
   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,   // no transfer open
      PH_ADDR = 3'd1,   // waiting for first byte after start
      PH_ACK  = 3'd2,   // master: waiting for acknowledge of first byte
      PH_DATA = 3'd3,   // transfer running, nothing left to decode
      PH_SKIP = 3'd4    // slave not addressed: ignore until next start
   } phase_t;

endpackage

// File: rtl/i2crd_addr_cfg.sv
module i2crd_addr_cfg #(
   parameter int ADDR_W  = 7,
   parameter bit FREE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [ADDR_W:0]   cfg_wdata,
   output logic [ADDR_W-1:0] own_addr,
   output logic              free_mode
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         own_addr <= '0;
      else if (cfg_we)
         own_addr <= cfg_wdata[ADDR_W:1];
   end

   generate
      if (FREE_EN) begin : g_free
         logic free_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               free_q <= 1'b0;
            else if (cfg_we)
               free_q <= cfg_wdata[0];
         end
         assign free_mode = free_q;
      end else begin : g_addr_only
         assign free_mode = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/i2crd_addr_cmp.sv
module i2crd_addr_cmp #(
   parameter int ADDR_W = 7
) (
   input  logic [ADDR_W:0]   byte_data,
   input  logic [ADDR_W-1:0] own_addr,
   output logic              match,
   output logic              dir_bit
);

   assign match   = (byte_data[ADDR_W:1] == own_addr);
   assign dir_bit = byte_data[0];

endmodule

// File: rtl/i2crd_phase_fsm.sv
module i2crd_phase_fsm
   import i2crd_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic bus_start,
   input  logic bus_clear,
   input  logic byte_valid,
   input  logic byte_dir,
   input  logic addr_match,
   input  logic ack_valid,
   input  logic ack_ok,
   input  logic is_master,
   input  logic free_mode,
   output logic hw_dir_we,
   output logic hw_dir_val,
   output logic hit_set
);

   phase_t phase_q, phase_d;
   logic   sent_dir_q;
   logic   first_byte;
   logic   quiet;

   assign quiet      = !bus_clear && !bus_start;
   assign first_byte = quiet && (phase_q == PH_ADDR) && byte_valid;

   always_comb begin
      phase_d = phase_q;
      if (bus_clear)
         phase_d = PH_IDLE;
      else if (bus_start)
         phase_d = PH_ADDR;
      else begin
         unique case (phase_q)
            PH_ADDR: if (byte_valid) begin
               if (free_mode)       phase_d = PH_DATA;
               else if (is_master)  phase_d = PH_ACK;
               else if (addr_match) phase_d = PH_DATA;
               else                 phase_d = PH_SKIP;
            end
            PH_ACK:  if (ack_valid) phase_d = PH_DATA;
            PH_IDLE, PH_DATA, PH_SKIP: phase_d = phase_q;
            default: phase_d = PH_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q    <= PH_IDLE;
         sent_dir_q <= 1'b0;
      end else begin
         phase_q <= phase_d;
         if (first_byte && is_master)
            sent_dir_q <= byte_dir;
      end
   end

   logic slave_hit;
   logic master_acked;

   assign slave_hit    = first_byte && !free_mode && !is_master && addr_match;
   assign master_acked = quiet && (phase_q == PH_ACK) && ack_valid && ack_ok
                         && !free_mode;

   assign hit_set    = slave_hit;
   assign hw_dir_we  = slave_hit || master_acked;
   assign hw_dir_val = slave_hit ? byte_dir : !sent_dir_q;

endmodule

// File: rtl/i2crd_flag_regs.sv
module i2crd_flag_regs (
   input  logic clk,
   input  logic rst_n,
   input  logic bus_clear,
   input  logic bus_start,
   input  logic ctrl_we,
   input  logic ctrl_master,
   input  logic ctrl_xmit,
   input  logic hw_dir_we,
   input  logic hw_dir_val,
   input  logic hit_set,
   output logic is_master,
   output logic is_xmit,
   output logic addr_hit
);

   // Priority per flag: bus clear, then hardware update, then software.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         is_master <= 1'b0;
         is_xmit   <= 1'b0;
         addr_hit  <= 1'b0;
      end else begin
         if (bus_clear)
            is_master <= 1'b0;
         else if (ctrl_we)
            is_master <= ctrl_master;

         if (bus_clear)
            is_xmit <= 1'b0;
         else if (hw_dir_we)
            is_xmit <= hw_dir_val;
         else if (ctrl_we)
            is_xmit <= ctrl_xmit;

         if (bus_clear || bus_start)
            addr_hit <= 1'b0;
         else if (hit_set)
            addr_hit <= 1'b1;
      end
   end

endmodule

// File: rtl/i2crd_tracker.sv
module i2crd_tracker #(
   parameter int ADDR_W  = 7,
   parameter bit FREE_EN = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cfg_we,
   input  logic [ADDR_W:0] cfg_wdata,
   input  logic            ctrl_we,
   input  logic            ctrl_master,
   input  logic            ctrl_xmit,
   input  logic            bus_start,
   input  logic            bus_stop,
   input  logic            bus_arb_lost,
   input  logic            byte_valid,
   input  logic [ADDR_W:0] byte_data,
   input  logic            ack_valid,
   input  logic            ack_ok,
   output logic            is_master,
   output logic            is_xmit,
   output logic            addr_hit
);

   localparam int BYTE_W = ADDR_W + 1;

   generate
      if (ADDR_W < 1 || ADDR_W > 15) begin : g_bad_width
         $error("i2crd_tracker: ADDR_W must lie in 1..15");
      end
      if (BYTE_W != $bits(byte_data)) begin : g_bad_byte
         $error("i2crd_tracker: byte width mismatch");
      end
   endgenerate

   logic [ADDR_W-1:0] own_addr;
   logic              free_mode;
   logic              addr_match;
   logic              dir_bit;
   logic              bus_clear;
   logic              hw_dir_we;
   logic              hw_dir_val;
   logic              hit_set;

   assign bus_clear = bus_stop || bus_arb_lost;

   i2crd_addr_cfg #(.ADDR_W(ADDR_W), .FREE_EN(FREE_EN)) cfg_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_wdata (cfg_wdata),
      .own_addr  (own_addr),
      .free_mode (free_mode)
   );

   i2crd_addr_cmp #(.ADDR_W(ADDR_W)) cmp_i (
      .byte_data (byte_data),
      .own_addr  (own_addr),
      .match     (addr_match),
      .dir_bit   (dir_bit)
   );

   i2crd_phase_fsm fsm_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_start  (bus_start),
      .bus_clear  (bus_clear),
      .byte_valid (byte_valid),
      .byte_dir   (dir_bit),
      .addr_match (addr_match),
      .ack_valid  (ack_valid),
      .ack_ok     (ack_ok),
      .is_master  (is_master),
      .free_mode  (free_mode),
      .hw_dir_we  (hw_dir_we),
      .hw_dir_val (hw_dir_val),
      .hit_set    (hit_set)
   );

   i2crd_flag_regs flags_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_clear   (bus_clear),
      .bus_start   (bus_start),
      .ctrl_we     (ctrl_we),
      .ctrl_master (ctrl_master),
      .ctrl_xmit   (ctrl_xmit),
      .hw_dir_we   (hw_dir_we),
      .hw_dir_val  (hw_dir_val),
      .hit_set     (hit_set),
      .is_master   (is_master),
      .is_xmit     (is_xmit),
      .addr_hit    (addr_hit)
   );

endmodule

// File: rtl/i2crd_tracker_chk.sv
module i2crd_tracker_chk (
   input logic clk,
   input logic rst_n,
   input logic ctrl_we,
   input logic ctrl_master,
   input logic bus_start,
   input logic bus_stop,
   input logic bus_arb_lost,
   input logic byte_valid,
   input logic ack_valid,
   input logic ack_ok,
   input logic free_mode,
   input logic is_master,
   input logic is_xmit,
   input logic addr_hit
);

   assert_clear_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_stop || bus_arb_lost) |=> (!is_master && !is_xmit && !addr_hit));

   assert_restart_drops_hit_R10: assert property (@(posedge clk) disable iff (!rst_n)
      bus_start |=> !addr_hit);

   assert_free_holds_dir_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (free_mode && !ctrl_we && !bus_stop && !bus_arb_lost) |=> $stable(is_xmit));

   assert_nack_holds_dir_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_valid && !ack_ok && !byte_valid && !ctrl_we && !bus_stop && !bus_arb_lost)
      |=> $stable(is_xmit));

   assert_hit_from_slave_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(addr_hit) |-> ($past(byte_valid) && !$past(is_master)));

   assert_ctrl_role_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_we && !bus_stop && !bus_arb_lost) |=> (is_master == $past(ctrl_master)));

endmodule

bind i2crd_tracker i2crd_tracker_chk chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .ctrl_we      (ctrl_we),
   .ctrl_master  (ctrl_master),
   .bus_start    (bus_start),
   .bus_stop     (bus_stop),
   .bus_arb_lost (bus_arb_lost),
   .byte_valid   (byte_valid),
   .ack_valid    (ack_valid),
   .ack_ok       (ack_ok),
   .free_mode    (free_mode),
   .is_master    (is_master),
   .is_xmit      (is_xmit),
   .addr_hit     (addr_hit)
);

// File: tb/i2crd_tracker_tb.sv
module i2crd_tracker_tb_top;

   localparam int VW  = 26;
   localparam int NV  = 38;
   localparam logic [6:0] OWN = 7'h2A;

   // Vector layout: [25:22] req, [21] start, [20] stop, [19] arb, [18] byte_valid,
   // [17:10] byte, [9] ack_valid, [8] ack_ok, [7] ctrl_we, [6] ctrl_master,
   // [5] ctrl_xmit, [4] cfg_we (writes {OWN,fmt}), [3] fmt, [2:0] expected m,x,hit
   function automatic logic [VW-1:0] mkv(
      input logic [3:0] rq, input logic s, input logic p, input logic a,
      input logic bv, input logic [7:0] bd, input logic av, input logic ak,
      input logic cw, input logic cm, input logic cx, input logic fw, input logic ff,
      input logic em, input logic ex, input logic eh);
      return {rq, s, p, a, bv, bd, av, ak, cw, cm, cx, fw, ff, em, ex, eh};
   endfunction

   localparam logic [VW-1:0] VEC [NV] = '{
      mkv(2, 0,0,0, 0,8'h00, 0,0, 0,0,0, 1,0, 0,0,0), // R2 own address 0x2A, addressing
      // master write
      mkv(3, 0,0,0, 0,8'h00, 0,0, 1,1,1, 0,0, 1,1,0), // R3
      mkv(7, 1,0,0, 0,8'h00, 0,0, 0,0,0, 0,0, 1,1,0),
      mkv(7, 0,0,0, 1,8'h54, 0,0, 0,0,0, 0,0, 1,1,0), // R7 own address sent, no hit as master
      mkv(7, 0,0,0, 0,8'h00, 1,1, 0,0,0, 0,0, 1,1,0), // R7 dir 0 acked -> xmit 1
      mkv(4, 0,1,0, 0,8'h00, 0,0, 0,0,0, 0,0, 0,0,0), // R4 stop
      // master read, then arbitration loss
      mkv(3, 0,0,0, 0,8'h00, 0,0, 1,1,1, 0,0, 1,1,0),
      mkv(7, 1,0,0, 0,8'h00, 0,0, 0,0,0, 0,0, 1,1,0),
      mkv(7, 0,0,0, 1,8'hA1, 0,0, 0,0,0, 0,0, 1,1,0),
      mkv(7, 0,0,0, 0,8'h00, 1,1, 0,0,0, 0,0, 1,0,0), // R7 dir 1 acked -> xmit 0
      mkv(4, 0,0,1, 0,8'h00, 0,0, 0,0,0, 0,0, 0,0,0), // R4 arbitration loss
      // master NACK
      mkv(3, 0,0,0, 0,8'h00, 0,0, 1,1,1, 0,0, 1,1,0),
      mkv(8, 1,0,0, 0,8'h00, 0,0, 0,0,0, 0,0, 1,1,0),
      mkv(8, 0,0,0, 1,8'h33, 0,0, 0,0,0, 0,0, 1,1,0),
      mkv(8, 0,0,0, 0,8'h00, 1,0, 0,0,0, 0,0, 1,1,0), // R8 nack keeps xmit
      mkv(4, 0,1,0, 0,8'h00, 0,0, 0,0,0, 0,0, 0,0,0),
      // slave hits
      mkv(5, 1,0,0, 0,8'h00, 0,0, 0,0,0, 0,0, 0,0,0),
      mkv(5, 0,0,0, 1,8'h55, 0,0, 0,0,0, 0,0, 0,1,1), // R5 hit, read -> xmit 1
      mkv(10,0,0,0, 1,8'h12, 0,0, 0,0,0, 0,0, 0,1,1), // R10 hit persists over data
      mkv(10,1,0,0, 0,8'h00, 0,0, 0,0,0, 0,0, 0,1,0), // R10 repeated start drops hit
      mkv(5, 0,0,0, 1,8'h54, 0,0, 0,0,0, 0,0, 0,0,1), // R5 hit, write -> xmit 0
      mkv(10,0,1,0, 0,8'h00, 0,0, 0,0,0, 0,0, 0,0,0), // R10 stop drops hit
      // slave miss
      mkv(3, 0,0,0, 0,8'h00, 0,0, 1,0,1, 0,0, 0,1,0),
      mkv(6, 1,0,0, 0,8'h00, 0,0, 0,0,0, 0,0, 0,1,0),
      mkv(6, 0,0,0, 1,8'h57, 0,0, 0,0,0, 0,0, 0,1,0), // R6 miss, flags unchanged
      mkv(6, 0,0,0, 1,8'h54, 0,0, 0,0,0, 0,0, 0,1,0), // R6 later matching byte ignored
      mkv(4, 0,1,0, 0,8'h00, 0,0, 0,0,0, 0,0, 0,0,0),
      // collision
      mkv(4, 0,1,0, 0,8'h00, 0,0, 1,1,1, 0,0, 0,0,0), // R4 clear beats ctrl write
      // free data format
      mkv(2, 0,0,0, 0,8'h00, 0,0, 0,0,0, 1,1, 0,0,0), // R2 select free data
      mkv(9, 1,0,0, 0,8'h00, 0,0, 0,0,0, 0,0, 0,0,0),
      mkv(9, 0,0,0, 1,8'h55, 0,0, 0,0,0, 0,0, 0,0,0), // R9 no hit, no xmit change
      mkv(9, 0,0,0, 0,8'h00, 1,1, 0,0,0, 0,0, 0,0,0),
      mkv(9, 0,0,0, 0,8'h00, 0,0, 1,1,1, 0,0, 1,1,0),
      mkv(9, 1,0,0, 0,8'h00, 0,0, 0,0,0, 0,0, 1,1,0),
      mkv(9, 0,0,0, 1,8'h55, 0,0, 0,0,0, 0,0, 1,1,0),
      mkv(9, 0,0,0, 0,8'h00, 1,1, 0,0,0, 0,0, 1,1,0), // R9 master ack ignored
      mkv(4, 0,1,0, 0,8'h00, 0,0, 0,0,0, 0,0, 0,0,0),
      mkv(2, 0,0,0, 0,8'h00, 0,0, 0,0,0, 1,0, 0,0,0)  // R2 back to addressing
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic [7:0] cfg_wdata = '0;
   logic       ctrl_we = 1'b0, ctrl_master = 1'b0, ctrl_xmit = 1'b0;
   logic       bus_start = 1'b0, bus_stop = 1'b0, bus_arb_lost = 1'b0;
   logic       byte_valid = 1'b0;
   logic [7:0] byte_data = '0;
   logic       ack_valid = 1'b0, ack_ok = 1'b0;
   logic       is_master, is_xmit, addr_hit;

   int n_checks = 0;
   int n_fails  = 0;

   always #10 clk = ~clk;

   i2crd_tracker dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .ctrl_we(ctrl_we), .ctrl_master(ctrl_master), .ctrl_xmit(ctrl_xmit),
      .bus_start(bus_start), .bus_stop(bus_stop), .bus_arb_lost(bus_arb_lost),
      .byte_valid(byte_valid), .byte_data(byte_data),
      .ack_valid(ack_valid), .ack_ok(ack_ok),
      .is_master(is_master), .is_xmit(is_xmit), .addr_hit(addr_hit)
   );

   task automatic check(input string req, input logic [2:0] exp);
      n_checks++;
      if ({is_master, is_xmit, addr_hit} !== exp) begin
         n_fails++;
         $display("FAIL %s: {m,x,hit} actual %b expected %b at %0t",
                  req, {is_master, is_xmit, addr_hit}, exp, $time);
      end
   endtask

   task automatic idle_inputs();
      cfg_we = 0; ctrl_we = 0; ctrl_master = 0; ctrl_xmit = 0;
      bus_start = 0; bus_stop = 0; bus_arb_lost = 0;
      byte_valid = 0; byte_data = '0; ack_valid = 0; ack_ok = 0;
   endtask

   // Called at a falling edge: drive, let one rising edge pass, come back.
   task automatic apply(input logic [VW-1:0] v);
      bus_start    = v[21];
      bus_stop     = v[20];
      bus_arb_lost = v[19];
      byte_valid   = v[18];
      byte_data    = v[17:10];
      ack_valid    = v[9];
      ack_ok       = v[8];
      ctrl_we      = v[7];
      ctrl_master  = v[6];
      ctrl_xmit    = v[5];
      cfg_we       = v[4];
      cfg_wdata    = {OWN, v[3]};
      @(negedge clk);
      idle_inputs();
   endtask

   initial begin
      #(20 * 200000);
      n_fails++;
      $display("FAIL watchdog: actual still running, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

   initial begin
      idle_inputs();
      repeat (3) @(negedge clk);
      check("R1", 3'b000);                       // R1 during reset
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", 3'b000);                       // R1 after release

      for (int i = 0; i < NV; i++) begin
         apply(VEC[i]);
         check($sformatf("R%0d vec%0d", VEC[i][25:22], i), VEC[i][2:0]);
      end

      // R1: reset in the middle of operation, then own address back to 0
      apply(mkv(3, 0,0,0, 0,8'h00, 0,0, 1,1,1, 0,0, 1,1,0));
      check("R3", 3'b110);
      rst_n = 1'b0;
      @(negedge clk);
      check("R1", 3'b000);
      rst_n = 1'b1;
      @(negedge clk);
      apply(mkv(1, 1,0,0, 0,8'h00, 0,0, 0,0,0, 0,0, 0,0,0));
      apply(mkv(1, 0,0,0, 1,8'h55, 0,0, 0,0,0, 0,0, 0,0,0));
      check("R1 own address reset to zero", 3'b000); // 0x2A no longer matches
      apply(mkv(1, 1,0,0, 0,8'h00, 0,0, 0,0,0, 0,0, 0,0,0));
      apply(mkv(1, 0,0,0, 1,8'h01, 0,0, 0,0,0, 0,0, 0,1,1));
      check("R1 address 0 matches", 3'b011);

      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

endmodule